// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading two levels of translation entries from memory. A requester offers a linear address together with its access kind (read or write) and privilege (user or supervisor). The walker fetches a directory entry and then a table entry over a single-outstanding word port. It answers with either the physical address or a fault carrying a three-bit cause.

Along the way the walker maintains each entry's status bits. The Accessed bit is set in both levels, and the Dirty bit is set in the leaf entry on writes. Both are set before the answer is given, using read-modify-write cycles that hold the bus lock from the read through the write. The base of the directory sits in a register loaded from a port. A write-protect input, sampled when a request is accepted, decides whether supervisor writes may touch read-only pages.

Top module: `pgw_top`

## Requirements
- R1: The directory entry is read at {base[31:12], lin[31:22], 2'b00}. The table entry is read at {directory entry[31:12], lin[21:12], 2'b00}. The base comes from the most recent dbase_in load.
- R2: A successful walk answers with rsp_fault=0 and rsp_paddr = {table entry[31:12], lin[11:0]}.
- R3: When an entry has bit 0 (present) clear, the walk stops with a fault and cause bit 0 equal to 0. That entry is never written back. When the directory entry is absent, no table entry is read.
- R4: Bit 5 (accessed) is written to 1 in both entries before the answer is given. No write-back is issued for an entry whose required status bits are already set.
- R5: On a write access, bit 6 (dirty) of the table entry is set. On a read access it is left alone. Bit 6 of the directory entry is never changed.
- R6: Every write-back is issued with mem_lock high, and mem_lock was already high during the read that preceded it. mem_lock is low whenever the walker is idle.
- R7: A user access faults with cause bit 0 = 1 (protection) unless bit 2 (user allowed) is 1 in both entries.
- R8: A write faults on an entry whose bit 1 (writable) is 0 when the access is user, or when it is supervisor and write-protect is 1. A supervisor write to such an entry with write-protect 0 succeeds.
- R9: A write-back changes only bits 5 and 6. All other bits are kept, including the software bits 11:9 and the frame bits.
- R10: rsp_cause encodes bit 0 = protection (1) or not-present (0), bit 1 = write access, bit 2 = user access.
- R11: An entry that raises a protection fault is not written, so its accessed and dirty bits keep their values.
- R12: req_ready is high only when idle. Each accepted request yields exactly one single-cycle rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbase_we | input | 1 | Load the directory base register |
| dbase_in | input | 32 | New directory base value |
| wp_en | input | 1 | Supervisor write-protect control |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| rsp_valid | output | 1 | Answer valid (one cycle) |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 3 | Fault cause {user, write, protection} |
| rsp_paddr | output | 32 | Physical address (zero on fault) |
| mem_req | output | 1 | Memory access requested, held until mem_ack |
| mem_we | output | 1 | Access is a write-back |
| mem_lock | output | 1 | Bus lock for read-modify-write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Memory access completed |
| mem_rdata | input | 32 | Entry read data, valid with mem_ack |

## Verification
The hardest case to reach is a walk that fails at the second level after the first level has already been updated. In that case the directory entry must receive its accessed bit while the table entry stays untouched. The bench builds entry images in its memory model so that the directory entry permits the access and the table entry is absent or denies it. It then checks, per walk, the number of reads and write-backs as well as the final memory images. The same memory model logs any write that arrives without the lock held, and repeating a walk shows that write-backs are skipped once the status bits are set.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   localparam int unsigned BIT_PRESENT  = 0;
   localparam int unsigned BIT_WRITABLE = 1;
   localparam int unsigned BIT_USER     = 2;
   localparam int unsigned BIT_ACCESSED = 5;
   localparam int unsigned BIT_DIRTY    = 6;
   localparam int unsigned CAUSE_W      = 3;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_DIR_RD = 3'd1,
      ST_DIR_WR = 3'd2,
      ST_TBL_RD = 3'd3,
      ST_TBL_WR = 3'd4,
      ST_RESP   = 3'd5
   } walk_state_e;

   typedef struct packed {
      logic user;
      logic write;
      logic prot;
   } fault_cause_t;
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr #(
   parameter int unsigned AW    = 32,
   parameter int unsigned OFF_W = 12,
   parameter int unsigned IDX_W = 10
) (
   input  logic [AW-OFF_W-1:0] base_frame,
   input  logic [IDX_W-1:0]    index,
   output logic [AW-1:0]       entry_addr
);
   localparam int unsigned PAD_W = OFF_W - IDX_W;

   generate
      if (PAD_W < 1) begin : g_bad
         $error("pgw_addr: offset field must exceed index field");
      end
   endgenerate

   assign entry_addr = {base_frame, index, {PAD_W{1'b0}}};
endmodule

// File: rtl/pgw_rights.sv
module pgw_rights
   import pgw_pkg::*;
#(
   parameter int unsigned DW   = 32,
   parameter bit          LEAF = 1'b0
) (
   input  logic [DW-1:0] entry,
   input  logic          is_user,
   input  logic          is_write,
   input  logic          wp,
   output logic          not_present,
   output logic          prot_fault,
   output logic [DW-1:0] updated,
   output logic          need_wb
);
   logic          user_denied;
   logic          write_denied;
   logic [DW-1:0] set_mask;

   generate
      if (LEAF) begin : g_leaf
         always_comb begin
            set_mask = '0;
            set_mask[BIT_ACCESSED] = 1'b1;
            set_mask[BIT_DIRTY]    = is_write;
         end
      end else begin : g_dir
         always_comb begin
            set_mask = '0;
            set_mask[BIT_ACCESSED] = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      not_present  = ~entry[BIT_PRESENT];
      user_denied  = is_user & ~entry[BIT_USER];
      write_denied = is_write & ~entry[BIT_WRITABLE] & (is_user | wp);
      prot_fault   = ~not_present & (user_denied | write_denied);
      updated      = entry | set_mask;
      need_wb      = (updated != entry);
   end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
   import pgw_pkg::*;
#(
   parameter int unsigned AW    = 32,
   parameter int unsigned OFF_W = 12,
   parameter int unsigned IDX_W = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dbase_we,
   input  logic [AW-1:0] dbase_in,
   input  logic          wp_en,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_lin,
   input  logic          req_write,
   input  logic          req_user,
   output logic          rsp_valid,
   output logic          rsp_fault,
   output logic [2:0]    rsp_cause,
   output logic [AW-1:0] rsp_paddr,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_lock,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [AW-1:0] mem_rdata
);
   localparam int unsigned LEVELS = 2;
   localparam int unsigned PFN_W  = AW - OFF_W;

   generate
      if (LEVELS * IDX_W + OFF_W != AW) begin : g_bad_split
         $error("pgw_top: index and offset fields must cover the address");
      end
      if (OFF_W <= BIT_DIRTY) begin : g_bad_off
         $error("pgw_top: offset too narrow for status bits");
      end
   endgenerate

   walk_state_e   state_q;
   logic [AW-1:0] dbase_q;
   logic [AW-1:0] lin_q;
   logic          wr_q, usr_q, wp_q;
   logic [PFN_W-1:0] frame_q;
   logic [AW-1:0] ent_q;
   logic [AW-1:0] paddr_q;
   logic          fault_q;
   fault_cause_t  cause_q;

   logic [PFN_W-1:0] lvl_base [LEVELS];
   logic [IDX_W-1:0] lvl_idx  [LEVELS];
   logic [AW-1:0]    lvl_addr [LEVELS];
   logic             lvl_np   [LEVELS];
   logic             lvl_prot [LEVELS];
   logic [AW-1:0]    lvl_upd  [LEVELS];
   logic             lvl_wb   [LEVELS];

   assign lvl_base[0] = dbase_q[AW-1:OFF_W];
   assign lvl_base[1] = frame_q;

   generate
      for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
         localparam int unsigned HI = AW - 1 - l * IDX_W;
         assign lvl_idx[l] = lin_q[HI -: IDX_W];

         pgw_addr #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
            .base_frame (lvl_base[l]),
            .index      (lvl_idx[l]),
            .entry_addr (lvl_addr[l])
         );

         pgw_rights #(.DW(AW), .LEAF(l == LEVELS - 1)) u_rights (
            .entry       (mem_rdata),
            .is_user     (usr_q),
            .is_write    (wr_q),
            .wp          (wp_q),
            .not_present (lvl_np[l]),
            .prot_fault  (lvl_prot[l]),
            .updated     (lvl_upd[l]),
            .need_wb     (lvl_wb[l])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dbase_q <= '0;
         lin_q   <= '0;
         wr_q    <= 1'b0;
         usr_q   <= 1'b0;
         wp_q    <= 1'b0;
         frame_q <= '0;
         ent_q   <= '0;
         paddr_q <= '0;
         fault_q <= 1'b0;
         cause_q <= '0;
      end else begin
         if (dbase_we) dbase_q <= dbase_in;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  lin_q   <= req_lin;
                  wr_q    <= req_write;
                  usr_q   <= req_user;
                  wp_q    <= wp_en;
                  fault_q <= 1'b0;
                  cause_q <= '0;
                  state_q <= ST_DIR_RD;
               end
            end
            ST_DIR_RD: begin
               if (mem_ack) begin
                  if (lvl_np[0] || lvl_prot[0]) begin
                     fault_q <= 1'b1;
                     cause_q <= '{user: usr_q, write: wr_q, prot: lvl_prot[0]};
                     state_q <= ST_RESP;
                  end else begin
                     frame_q <= mem_rdata[AW-1:OFF_W];
                     ent_q   <= lvl_upd[0];
                     state_q <= lvl_wb[0] ? ST_DIR_WR : ST_TBL_RD;
                  end
               end
            end
            ST_DIR_WR: begin
               if (mem_ack) state_q <= ST_TBL_RD;
            end
            ST_TBL_RD: begin
               if (mem_ack) begin
                  if (lvl_np[1] || lvl_prot[1]) begin
                     fault_q <= 1'b1;
                     cause_q <= '{user: usr_q, write: wr_q, prot: lvl_prot[1]};
                     state_q <= ST_RESP;
                  end else begin
                     ent_q   <= lvl_upd[1];
                     paddr_q <= {mem_rdata[AW-1:OFF_W], lin_q[OFF_W-1:0]};
                     state_q <= lvl_wb[1] ? ST_TBL_WR : ST_RESP;
                  end
               end
            end
            ST_TBL_WR: begin
               if (mem_ack) state_q <= ST_RESP;
            end
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready = (state_q == ST_IDLE);
      rsp_valid = (state_q == ST_RESP);
      rsp_fault = fault_q;
      rsp_cause = cause_q;
      rsp_paddr = fault_q ? '0 : paddr_q;
      mem_req   = (state_q == ST_DIR_RD) || (state_q == ST_DIR_WR) ||
                  (state_q == ST_TBL_RD) || (state_q == ST_TBL_WR);
      mem_we    = (state_q == ST_DIR_WR) || (state_q == ST_TBL_WR);
      mem_lock  = mem_req;
      mem_addr  = ((state_q == ST_TBL_RD) || (state_q == ST_TBL_WR)) ? lvl_addr[1] : lvl_addr[0];
      mem_wdata = ent_q;
   end
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
   parameter int unsigned AW    = 32,
   parameter int unsigned OFF_W = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [AW-1:0] req_lin,
   input logic          rsp_valid,
   input logic          rsp_fault,
   input logic [AW-1:0] rsp_paddr,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_lock,
   input logic          mem_ack,
   input logic [AW-1:0] mem_wdata,
   input logic [AW-1:0] mem_rdata
);
   localparam logic [AW-1:0] STATUS_MASK = AW'(32'h60);

   logic [AW-1:0] rd_last;
   logic [AW-1:0] lin_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_last  <= '0;
         lin_seen <= '0;
      end else begin
         if (mem_req && mem_ack && !mem_we) rd_last <= mem_rdata;
         if (req_valid && req_ready) lin_seen <= req_lin;
      end
   end

   AST_WB_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_lock && $past(mem_lock))); // R6
   AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_lock); // R6
   AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[5]); // R4
   AST_WB_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ((mem_wdata & ~STATUS_MASK) == (rd_last & ~STATUS_MASK))); // R9
   AST_WB_ONLY_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> rd_last[0]); // R3
   AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == lin_seen[OFF_W-1:0])); // R2
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R12
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req); // R1
endmodule

bind pgw_top pgw_chk #(.AW(AW), .OFF_W(OFF_W)) u_pgw_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_lin   (req_lin),
   .rsp_valid (rsp_valid),
   .rsp_fault (rsp_fault),
   .rsp_paddr (rsp_paddr),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_lock  (mem_lock),
   .mem_ack   (mem_ack),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata)
);

// File: tb/tb_pgw_top.sv
module tb_pgw_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbase_we = 1'b0;
   logic [31:0] dbase_in = '0;
   logic        wp_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_lin = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_valid, rsp_fault;
   logic [2:0]  rsp_cause;
   logic [31:0] rsp_paddr;
   logic        mem_req, mem_we, mem_lock;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgw_top dut (.*);

   logic [31:0] mem [logic [31:0]];
   int          n_rd = 0, n_wr = 0, lock_bad = 0;
   logic [31:0] rd_log [64];
   int          n_chk = 0, n_fail = 0;

   function automatic logic [31:0] peek(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(posedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            n_wr++;
            if (!mem_lock) lock_bad++;
         end else begin
            mem_rdata <= peek(mem_addr);
            rd_log[n_rd % 64] = mem_addr;
            n_rd++;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   localparam logic [31:0] BASE  = 32'h0001_0000;
   localparam logic [31:0] LIN   = 32'h0040_3ABC;
   localparam logic [31:0] PDE_A = 32'h0001_0004;
   localparam logic [31:0] PTE_A = 32'h0002_000C;
   localparam logic [31:0] FRAME = 32'h0ABC_D000;
   localparam logic [31:0] PADDR = 32'h0ABC_DABC;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   logic        r_fault;
   logic [2:0]  r_cause;
   logic [31:0] r_paddr;
   int          d_rd, d_wr, rd0;

   task automatic walk(input logic wr, input logic usr, input logic wp);
      int b_rd = n_rd;
      int b_wr = n_wr;
      int pulses = 0;
      @(negedge clk);
      wp_en = wp; req_lin = LIN; req_write = wr; req_user = usr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t < 200; t++) begin
         if (rsp_valid) begin
            pulses++;
            r_fault = rsp_fault; r_cause = rsp_cause; r_paddr = rsp_paddr;
            break;
         end
         @(negedge clk);
      end
      if (pulses == 0) begin
         n_chk++; n_fail++;
         $display("FAIL R12: watchdog, actual no response expected response");
      end
      @(negedge clk);
      chk("R12 single pulse", {31'd0, rsp_valid}, 32'd0);
      chk("R6 lock released", {31'd0, mem_lock}, 32'd0);
      d_rd = n_rd - b_rd;
      d_wr = n_wr - b_wr;
      rd0  = b_rd;
   endtask

   task automatic setup(input logic [31:0] pde, input logic [31:0] pte);
      mem[PDE_A] = pde;
      mem[PTE_A] = pte;
   endtask

   task automatic t_reset;
      chk("R12 ready after reset", {31'd0, req_ready}, 32'd1);
      chk("R12 no rsp after reset", {31'd0, rsp_valid}, 32'd0);
      chk("R6 no lock after reset", {31'd0, mem_lock}, 32'd0);
   endtask

   task automatic t_read_fresh;
      setup(32'h0002_0007, FRAME | 32'h7);
      walk(1'b0, 1'b1, 1'b0);
      chk("R2 paddr", r_paddr, PADDR);
      chk("R2 no fault", {31'd0, r_fault}, 32'd0);
      chk("R1 dir addr", rd_log[rd0 % 64], PDE_A);
      chk("R1 tbl addr", rd_log[(rd0 + 1) % 64], PTE_A);
      chk("R4 dir accessed", peek(PDE_A), 32'h0002_0027);
      chk("R5 read keeps dirty clear", peek(PTE_A), FRAME | 32'h27);
      chk("R4 two write-backs", d_wr, 2);
   endtask

   task automatic t_read_again;
      walk(1'b0, 1'b1, 1'b0);
      chk("R4 skip write-back", d_wr, 0);
      chk("R2 paddr repeat", r_paddr, PADDR);
   endtask

   task automatic t_user_write;
      walk(1'b1, 1'b1, 1'b0);
      chk("R5 dirty set", peek(PTE_A), FRAME | 32'h67);
      chk("R5 dir dirty untouched", peek(PDE_A), 32'h0002_0027);
      chk("R4 one write-back", d_wr, 1);
   endtask

   task automatic t_dir_absent;
      setup(32'h0002_0E06, FRAME | 32'h7);
      walk(1'b0, 1'b1, 1'b0);
      chk("R3 fault", {31'd0, r_fault}, 32'd1);
      chk("R10 cause user read np", {29'd0, r_cause}, 32'h4);
      chk("R3 one read", d_rd, 1);
      chk("R3 no write", d_wr, 0);
      chk("R2 paddr zero on fault", r_paddr, 32'h0);
   endtask

   task automatic t_tbl_absent;
      setup(32'h0002_0007, FRAME | 32'h6);
      walk(1'b1, 1'b0, 1'b0);
      chk("R10 cause sup write np", {29'd0, r_cause}, 32'h2);
      chk("R4 dir updated before tbl fault", peek(PDE_A), 32'h0002_0027);
      chk("R3 tbl untouched", peek(PTE_A), FRAME | 32'h6);
   endtask

   task automatic t_user_denied;
      setup(32'h0002_0027, FRAME | 32'h3);
      walk(1'b0, 1'b1, 1'b0);
      chk("R7 cause user prot", {29'd0, r_cause}, 32'h5);
      chk("R11 tbl not written", peek(PTE_A), FRAME | 32'h3);
      chk("R11 no write", d_wr, 0);
   endtask

   task automatic t_sup_wp;
      setup(32'h0002_0027, FRAME | 32'h5);
      walk(1'b1, 1'b0, 1'b1);
      chk("R8 wp=1 faults", {29'd0, r_cause}, 32'h3);
      chk("R11 ro tbl unchanged", peek(PTE_A), FRAME | 32'h5);
      walk(1'b1, 1'b0, 1'b0);
      chk("R8 wp=0 allowed", {31'd0, r_fault}, 32'd0);
      chk("R8 dirty on ro sup write", peek(PTE_A), FRAME | 32'h65);
   endtask

   task automatic t_user_ro_dir;
      setup(32'h0002_0005, FRAME | 32'h7);
      walk(1'b1, 1'b1, 1'b0);
      chk("R8 user write ro dir", {29'd0, r_cause}, 32'h7);
      chk("R11 dir not written", peek(PDE_A), 32'h0002_0005);
   endtask

   task automatic t_sw_bits;
      setup(32'h0002_0A07, FRAME | 32'hE07);
      walk(1'b1, 1'b0, 1'b0);
      chk("R9 tbl sw bits kept", peek(PTE_A), FRAME | 32'hE67);
      chk("R9 dir sw bits kept", peek(PDE_A), 32'h0002_0A27);
      chk("R6 no unlocked write", lock_bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      dbase_in = BASE; dbase_we = 1'b1;
      @(negedge clk);
      dbase_we = 1'b0;
      t_read_fresh();
      t_read_again();
      t_user_write();
      t_dir_absent();
      t_tbl_absent();
      t_user_denied();
      t_sup_wp();
      t_user_ro_dir();
      t_sw_bits();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL R12: global watchdog, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule